// File: doc/BRIEF.md
# Root Port Configuration Access Filter

This block sits ahead of the configuration path of a PCIe root port and screens every configuration access before anything else acts on it. For each request it looks at the target bus, device, function and register offset, the direction and size of the access, and the link status. It then issues one of four routing decisions. The access can go to the root port's own registers, or it can be forwarded downstream as a packet request. If the target must not be reached, a read is answered with sized all-ones data and a write is silently discarded.

The filter hides the bridge's first base address register from enumeration software. It admits only device 0 on the root bus and on the bus directly below it. It refuses all downstream traffic while the data link layer reports the link as inactive. It keeps its own copy of the root bus number. That copy is seeded from a configuration input after reset and then follows every accepted local write to the primary bus number register. Building the packets and holding the root port register contents are left to neighbouring logic.

Top module: `cfg_access_filter`

## Requirements
- R1: An access whose bus equals the stored root bus number, to device 0, that is not hidden by R2, gets the local decision (code 0) for both reads and writes, whatever the link status.
- R2: A root bus access to device 0, function 0, offset 0x010 is hidden: a read gets the all-ones decision (code 2), a write gets the drop decision (code 3). Another function or offset at the same device is not hidden.
- R3: While bit 13 of the link status halfword is 0, every access to a bus other than the root bus is invalid; the other 15 bits of that halfword have no effect.
- R4: A root bus access to any device number above 0 is invalid.
- R5: An access to bus (root + 1, modulo 256) with a device number above 0 is invalid; device 0 there, and any device on buses further down, are not made invalid by this rule.
- R6: An invalid read gets the all-ones decision (code 2), and an invalid write gets the drop decision (code 3).
- R7: A valid access to a bus other than the root bus gets the forward decision (code 1).
- R8: With the all-ones decision, the response data is right-justified ones sized to the access: size code 0 (byte) gives 0x000000FF, code 1 (halfword) gives 0x0000FFFF, code 2 (word) gives 0xFFFFFFFF. With any other decision the response data is 0.
- R9: A write that receives the local decision at offset 0x018 replaces the stored root bus number with bits 7:0 of the write data. The new value appears on the root bus output in the same cycle as that decision. No read, no write with another decision and no write to another offset changes it.
- R10: After reset the stored root bus number equals the configuration input.
- R11: The decision valid flag is high in the cycle after exactly each cycle where a request is valid. Its decision code and data stay registered until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_root_bus | input | 8 | Root bus number loaded after reset |
| link_status | input | 16 | Link status halfword of the root port; bit 13 is link active |
| req_valid | input | 1 | A configuration access is presented this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Target register byte offset |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, bits 7:0 used for the root bus update |
| dec_valid | output | 1 | Decision valid, one cycle after the request |
| dec_kind | output | 2 | Decision: 0 local, 1 forward, 2 all-ones, 3 drop |
| dec_rdata | output | 32 | Sized all-ones response data, else 0 |
| root_bus | output | 8 | Currently stored root bus number |

## Verification
Almost all internal state lives in the stored root bus number, so a wrong value shows at the ports on the next access. Root accesses get forwarded or refused, and the neighbouring bus (root + 1) loses its single-slot rule. The value is also driven out directly, so a missed or spurious update is visible in the same cycle as the decision for the write that caused it. Each decision is registered once, so a wrong routing or a missized all-ones word appears exactly one cycle after the offending request and nowhere later.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;

  typedef enum logic [1:0] {
    ROUTE_LOCAL = 2'd0,
    ROUTE_FWD   = 2'd1,
    ROUTE_ONES  = 2'd2,
    ROUTE_DROP  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

endpackage

// File: rtl/cfgf_rst_sync.sv
module cfgf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfgf_classify.sv
module cfgf_classify
  import cfgf_pkg::*;
#(
  parameter int          BUS_W    = 8,
  parameter int          DEV_W    = 5,
  parameter int          FN_W     = 3,
  parameter int          OFF_W    = 12,
  parameter logic [11:0] BAR0_OFF = 12'h010
) (
  input  logic [BUS_W-1:0] root_bus,
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off,
  input  logic             wr,
  input  logic             link_up,
  output route_e           kind
);

  localparam logic [OFF_W-1:0] HIDE_OFF = OFF_W'(BAR0_OFF);

  logic [BUS_W-1:0] below_bus;
  logic             on_root;
  logic             on_below;
  logic             dev_zero;
  logic             hidden;
  logic             no_link;
  logic             extra_slot;
  logic             refused;

  always_comb begin
    below_bus  = root_bus + BUS_W'(1);
    on_root    = (bus == root_bus);
    on_below   = (bus == below_bus);
    dev_zero   = (dev == '0);
    hidden     = on_root && dev_zero && (fn == '0) && (off == HIDE_OFF);
    no_link    = !on_root && !link_up;
    extra_slot = !dev_zero && (on_root || on_below);
    refused    = hidden || no_link || extra_slot;
    if (refused) begin
      kind = wr ? ROUTE_DROP : ROUTE_ONES;
    end else if (on_root) begin
      kind = ROUTE_LOCAL;
    end else begin
      kind = ROUTE_FWD;
    end
  end

endmodule

// File: rtl/cfgf_ones_gen.sv
module cfgf_ones_gen
  import cfgf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] ones
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] lane_on;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_on[i] = (i < 1);
        SZ_HALF: lane_on[i] = (i < 2);
        default: lane_on[i] = 1'b1;
      endcase
    end
    assign ones[8*i +: 8] = {8{lane_on[i]}};
  end

endmodule

// File: rtl/cfgf_root_track.sv
module cfgf_root_track #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] cfg_root_bus,
  input  logic             upd_en,
  input  logic [BUS_W-1:0] upd_val,
  output logic [BUS_W-1:0] root_bus
);

  logic [BUS_W-1:0] root_q;
  logic [BUS_W-1:0] root_d;
  logic             loaded_q;
  logic             loaded_d;
  logic             root_en;

  always_comb begin
    root_d   = root_q;
    loaded_d = loaded_q;
    root_en  = !loaded_q || upd_en;
    if (upd_en) begin
      root_d   = upd_val;
      loaded_d = 1'b1;
    end else if (!loaded_q) begin
      root_d   = cfg_root_bus;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q   <= '0;
      loaded_q <= 1'b0;
    end else if (root_en) begin
      root_q   <= root_d;
      loaded_q <= loaded_d;
    end
  end

  assign root_bus = loaded_q ? root_q : cfg_root_bus;

endmodule

// File: rtl/cfg_access_filter.sv
module cfg_access_filter
  import cfgf_pkg::*;
#(
  parameter int          BUS_W      = 8,
  parameter int          DEV_W      = 5,
  parameter int          FN_W       = 3,
  parameter int          OFF_W      = 12,
  parameter int          DATA_W     = 32,
  parameter int          LSTA_W     = 16,
  parameter int          LINK_BIT   = 13,
  parameter logic [11:0] BAR0_OFF   = 12'h010,
  parameter logic [11:0] PRIBUS_OFF = 12'h018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  cfg_root_bus,
  input  logic [LSTA_W-1:0] link_status,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              dec_valid,
  output logic [1:0]        dec_kind,
  output logic [DATA_W-1:0] dec_rdata,
  output logic [BUS_W-1:0]  root_bus
);

  localparam logic [OFF_W-1:0] UPD_OFF = OFF_W'(PRIBUS_OFF);

  logic              core_rst_n;
  logic              link_up;
  route_e            kind_nxt;
  logic [DATA_W-1:0] ones_val;
  logic              root_upd;

  logic              vld_q, vld_d;
  route_e            kind_q, kind_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              dec_en;

  cfgf_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign link_up = link_status[LINK_BIT];

  cfgf_classify #(
    .BUS_W    (BUS_W),
    .DEV_W    (DEV_W),
    .FN_W     (FN_W),
    .OFF_W    (OFF_W),
    .BAR0_OFF (BAR0_OFF)
  ) classify_i (
    .root_bus (root_bus),
    .bus      (req_bus),
    .dev      (req_dev),
    .fn       (req_fn),
    .off      (req_off),
    .wr       (req_wr),
    .link_up  (link_up),
    .kind     (kind_nxt)
  );

  cfgf_ones_gen #(.DATA_W(DATA_W)) ones_i (
    .size (req_size),
    .ones (ones_val)
  );

  assign root_upd = req_valid && req_wr && (kind_nxt == ROUTE_LOCAL) &&
                    (req_off == UPD_OFF);

  cfgf_root_track #(.BUS_W(BUS_W)) root_i (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .cfg_root_bus (cfg_root_bus),
    .upd_en       (root_upd),
    .upd_val      (req_wdata[BUS_W-1:0]),
    .root_bus     (root_bus)
  );

  always_comb begin
    vld_d   = req_valid;
    dec_en  = req_valid;
    kind_d  = kind_nxt;
    rdata_d = (kind_nxt == ROUTE_ONES) ? ones_val : '0;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      kind_q  <= ROUTE_LOCAL;
      rdata_q <= '0;
    end else if (dec_en) begin
      kind_q  <= kind_d;
      rdata_q <= rdata_d;
    end
  end

  assign dec_valid = vld_q;
  assign dec_kind  = kind_q;
  assign dec_rdata = rdata_q;

endmodule

// File: rtl/cfgf_checker.sv
module cfgf_checker #(
  parameter int          BUS_W      = 8,
  parameter int          DEV_W      = 5,
  parameter int          FN_W       = 3,
  parameter int          OFF_W      = 12,
  parameter int          DATA_W     = 32,
  parameter int          LSTA_W     = 16,
  parameter int          LINK_BIT   = 13,
  parameter logic [11:0] BAR0_OFF   = 12'h010,
  parameter logic [11:0] PRIBUS_OFF = 12'h018
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic [LSTA_W-1:0] link_status,
  input logic              req_valid,
  input logic              req_wr,
  input logic [BUS_W-1:0]  req_bus,
  input logic [DEV_W-1:0]  req_dev,
  input logic [FN_W-1:0]   req_fn,
  input logic [OFF_W-1:0]  req_off,
  input logic [1:0]        req_size,
  input logic              dec_valid,
  input logic [1:0]        dec_kind,
  input logic [DATA_W-1:0] dec_rdata,
  input logic [BUS_W-1:0]  root_bus
);

  localparam logic [OFF_W-1:0] HIDE_OFF = OFF_W'(BAR0_OFF);
  localparam logic [OFF_W-1:0] UPD_OFF  = OFF_W'(PRIBUS_OFF);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!core_rst_n)
    dec_valid == $past(req_valid));

  a_r2_hidden_read: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req_valid && !req_wr && req_bus == root_bus && req_dev == '0 &&
     req_fn == '0 && req_off == HIDE_OFF) |=> (dec_kind == 2'd2));

  a_r3_no_link: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req_valid && req_bus != root_bus && !link_status[LINK_BIT]) |=> dec_kind[1]);

  a_r4_root_slot: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req_valid && req_bus == root_bus && req_dev != '0) |=> dec_kind[1]);

  a_r6_drop_is_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dec_valid && dec_kind == 2'd3) |-> $past(req_wr));

  a_r8_byte_ones: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dec_valid && dec_kind == 2'd2 && $past(req_size) == 2'd0) |->
    (dec_rdata == DATA_W'(8'hFF)));

  a_r8_zero_otherwise: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dec_valid && dec_kind != 2'd2) |-> (dec_rdata == '0));

  a_r9_root_change_cause: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(root_bus) |-> $past(req_valid && req_wr && req_off == UPD_OFF));

endmodule

bind cfg_access_filter cfgf_checker #(
  .BUS_W      (BUS_W),
  .DEV_W      (DEV_W),
  .FN_W       (FN_W),
  .OFF_W      (OFF_W),
  .DATA_W     (DATA_W),
  .LSTA_W     (LSTA_W),
  .LINK_BIT   (LINK_BIT),
  .BAR0_OFF   (BAR0_OFF),
  .PRIBUS_OFF (PRIBUS_OFF)
) chk_i (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .link_status (link_status),
  .req_valid   (req_valid),
  .req_wr      (req_wr),
  .req_bus     (req_bus),
  .req_dev     (req_dev),
  .req_fn      (req_fn),
  .req_off     (req_off),
  .req_size    (req_size),
  .dec_valid   (dec_valid),
  .dec_kind    (dec_kind),
  .dec_rdata   (dec_rdata),
  .root_bus    (root_bus)
);

// File: tb/cfg_access_filter_tb_top.sv
`timescale 1ns/1ps
module cfg_access_filter_tb_top;

  localparam logic [1:0] K_LOC  = 2'd0;
  localparam logic [1:0] K_FWD  = 2'd1;
  localparam logic [1:0] K_ONES = 2'd2;
  localparam logic [1:0] K_DROP = 2'd3;
  localparam logic [15:0] LINK_ON  = 16'h2000;
  localparam logic [15:0] LINK_OFF = 16'hDFFF;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_root_bus;
  logic [15:0] link_status;
  logic        req_valid;
  logic        req_wr;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [11:0] req_off;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        dec_valid;
  logic [1:0]  dec_kind;
  logic [31:0] dec_rdata;
  logic [7:0]  root_bus;

  int checks;
  int fails;
  bit done;

  cfg_access_filter dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_root_bus (cfg_root_bus),
    .link_status  (link_status),
    .req_valid    (req_valid),
    .req_wr       (req_wr),
    .req_bus      (req_bus),
    .req_dev      (req_dev),
    .req_fn       (req_fn),
    .req_off      (req_off),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .dec_valid    (dec_valid),
    .dec_kind     (dec_kind),
    .dec_rdata    (dec_rdata),
    .root_bus     (root_bus)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [7:0] seed);
    @(negedge clk);
    rst_n        = 1'b0;
    cfg_root_bus = seed;
    req_valid    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input string req, input logic wr, input logic [7:0] bus,
                        input logic [4:0] dev, input logic [2:0] fn,
                        input logic [11:0] off, input logic [1:0] size,
                        input logic [31:0] wdata, input logic [1:0] exp_kind,
                        input logic [31:0] exp_rdata, input logic [7:0] exp_root);
    @(negedge clk);
    req_valid = 1'b1;
    req_wr    = wr;
    req_bus   = bus;
    req_dev   = dev;
    req_fn    = fn;
    req_off   = off;
    req_size  = size;
    req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'd0, dec_valid}, 32'd1);
    check({req, " kind"},  {30'd0, dec_kind}, {30'd0, exp_kind});
    check({req, " rdata"}, dec_rdata, exp_rdata);
    check({req, " root"},  {24'd0, root_bus}, {24'd0, exp_root});
  endtask

  task automatic t_reset_state;
    check("R10 root after reset", {24'd0, root_bus}, 32'h04);
    check("R11 idle valid", {31'd0, dec_valid}, 32'd0);
    check("R8 idle rdata", dec_rdata, 32'd0);
  endtask

  task automatic t_local;
    link_status = LINK_ON;
    access("R1 root rd", 1'b0, 8'h04, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, K_LOC, 32'h0, 8'h04);
    access("R1 root wr fn2", 1'b1, 8'h04, 5'd0, 3'd2, 12'h040, 2'd2, 32'hA5A5_A5A5, K_LOC, 32'h0, 8'h04);
    @(negedge clk);
    check("R11 valid drops after one cycle", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic t_hidden;
    access("R2 bar0 rd", 1'b0, 8'h04, 5'd0, 3'd0, 12'h010, 2'd2, 32'h0, K_ONES, 32'hFFFF_FFFF, 8'h04);
    access("R2 bar0 wr", 1'b1, 8'h04, 5'd0, 3'd0, 12'h010, 2'd2, 32'h1234_5678, K_DROP, 32'h0, 8'h04);
    access("R2 bar0 fn1 not hidden", 1'b0, 8'h04, 5'd0, 3'd1, 12'h010, 2'd2, 32'h0, K_LOC, 32'h0, 8'h04);
    access("R2 off 0x14 not hidden", 1'b0, 8'h04, 5'd0, 3'd0, 12'h014, 2'd2, 32'h0, K_LOC, 32'h0, 8'h04);
  endtask

  task automatic t_link_down;
    link_status = LINK_OFF;
    access("R3 down rd", 1'b0, 8'h05, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, K_ONES, 32'hFFFF_FFFF, 8'h04);
    access("R3 down wr", 1'b1, 8'h09, 5'd0, 3'd0, 12'h004, 2'd2, 32'h0, K_DROP, 32'h0, 8'h04);
    access("R3 R1 root while down", 1'b0, 8'h04, 5'd0, 3'd0, 12'h008, 2'd2, 32'h0, K_LOC, 32'h0, 8'h04);
    link_status = LINK_ON;
  endtask

  task automatic t_slots;
    access("R4 root dev1 half rd", 1'b0, 8'h04, 5'd1, 3'd0, 12'h000, 2'd1, 32'h0, K_ONES, 32'h0000_FFFF, 8'h04);
    access("R4 root dev1 wr", 1'b1, 8'h04, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, K_DROP, 32'h0, 8'h04);
    access("R5 below dev3 byte rd", 1'b0, 8'h05, 5'd3, 3'd0, 12'h001, 2'd0, 32'h0, K_ONES, 32'h0000_00FF, 8'h04);
    access("R5 below dev2 wr", 1'b1, 8'h05, 5'd2, 3'd0, 12'h000, 2'd2, 32'h0, K_DROP, 32'h0, 8'h04);
    access("R5 R7 below dev0", 1'b0, 8'h05, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, K_FWD, 32'h0, 8'h04);
    access("R5 R7 deeper dev7", 1'b0, 8'h06, 5'd7, 3'd5, 12'h100, 2'd2, 32'h0, K_FWD, 32'h0, 8'h04);
    access("R7 fwd wr", 1'b1, 8'h09, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0000_0077, K_FWD, 32'h0, 8'h04);
  endtask

  task automatic t_root_update;
    access("R9 rd 0x18 no update", 1'b0, 8'h04, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0, K_LOC, 32'h0, 8'h04);
    access("R9 dropped wr no update", 1'b1, 8'h04, 5'd1, 3'd0, 12'h018, 2'd2, 32'h0000_0033, K_DROP, 32'h0, 8'h04);
    access("R9 local wr 0x1c no update", 1'b1, 8'h04, 5'd0, 3'd0, 12'h01C, 2'd2, 32'h0000_0044, K_LOC, 32'h0, 8'h04);
    access("R9 update", 1'b1, 8'h04, 5'd0, 3'd0, 12'h018, 2'd2, 32'h1234_5610, K_LOC, 32'h0, 8'h10);
    access("R9 new root local", 1'b0, 8'h10, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, K_LOC, 32'h0, 8'h10);
    access("R9 old root fwd", 1'b0, 8'h04, 5'd3, 3'd0, 12'h000, 2'd2, 32'h0, K_FWD, 32'h0, 8'h10);
    access("R9 R5 new below dev1", 1'b0, 8'h11, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, K_ONES, 32'hFFFF_FFFF, 8'h10);
    access("R9 R5 wrap", 1'b1, 8'h10, 5'd0, 3'd0, 12'h018, 2'd0, 32'h0000_00FF, K_LOC, 32'h0, 8'hFF);
    access("R5 wrap below dev1", 1'b0, 8'h00, 5'd1, 3'd0, 12'h000, 2'd2, 32'h0, K_ONES, 32'hFFFF_FFFF, 8'hFF);
  endtask

  task automatic t_reseed;
    apply_reset(8'h30);
    check("R10 root after second reset", {24'd0, root_bus}, 32'h30);
    access("R10 R1 seeded root local", 1'b0, 8'h30, 5'd0, 3'd0, 12'h000, 2'd2, 32'h0, K_LOC, 32'h0, 8'h30);
  endtask

  initial begin
    checks      = 0;
    fails       = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    cfg_root_bus = 8'h04;
    link_status = LINK_ON;
    req_valid   = 1'b0;
    req_wr      = 1'b0;
    req_bus     = '0;
    req_dev     = '0;
    req_fn      = '0;
    req_off     = '0;
    req_size    = '0;
    req_wdata   = '0;
    apply_reset(8'h04);
    t_reset_state();
    t_local();
    t_hidden();
    t_link_down();
    t_slots();
    t_root_update();
    t_reseed();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule